// File: doc/BRIEF.md
# Parallel DAC Bus Sequencer

This block sits on the host side of a four-channel, double-buffered, voltage-output DAC. The DAC has a level-sensitive parallel interface. A single-cycle request names an operation, a channel, a data word and a buffering mode. The block turns that request into a timed sequence on the DAC's pins: channel address, read/write select, active-low chip select, active-low load strobe, write data with its output enable, and the read data that comes back. Every timing limit is given in nanoseconds as a parameter. Each one is converted to a whole number of system clock cycles, rounded up, when the block is elaborated.

The block supports four operations. A write goes to one input register, and it can also load the output register when single-buffer mode is selected. A read returns an input register. An update-all issues a bare load pulse. A batch writes all four input registers in turn and then gives one common load pulse, so that every channel output changes at the same moment. While a sequence runs, the block reports busy and ignores new requests.

Top module: `dac_bus_seq`

## Requirements
- R1: Out of reset, and whenever busy is low, chip select and load strobe are high (inactive), the data output enable is low, and read-valid is low.
- R2: A write (op code 2'b00) with default timing drives the address, the write select and the data for 2 cycles with chip select high. It then drives chip select low for 1 cycle and keeps address and data for 1 more cycle after chip select rises. Busy is high for exactly 4 cycles. The write word is bits [11:0] of the request data.
- R3: Before every chip-select fall, chip select stays high for at least 2 cycles while the address and read/write select are already stable.
- R4: A read (op code 2'b01) drives chip select low for 7 cycles with read/write select high (1 = read). It samples the DAC data in the last low cycle and presents it on the read-data output, with a read-valid pulse that lasts one cycle, in the first cycle after chip select rises.
- R5: After a read, the address and read select stay in place and busy stays high for 5 cycles after chip select rises, so that no write can drive the bus while the DAC is releasing it. A read occupies 14 busy cycles in all.
- R6: The data output enable is high only during the cycles of a write access, 4 per channel written, and never while read/write select is high.
- R7: A write with the single-buffer flag set drives the load strobe low during exactly the chip-select low cycle, so only the addressed output follows. With the flag clear, the load strobe stays high.
- R8: An update-all (op code 2'b10) drives the load strobe low for 2 cycles with chip select held high. There is no chip-select pulse, and busy lasts 2 cycles.
- R9: A batch (op code 2'b11) writes channels 0, 1, 2, 3 in that order, using data bits [k*12 +: 12] for channel k, with the load strobe high throughout. It then drives one load pulse of 2 cycles with chip select high. Busy lasts 18 cycles.
- R10: A request presented while busy is high is ignored. It alters no DAC register and does not lengthen the running sequence.
- R11: Operation codes are 2'b00 write, 2'b01 read, 2'b10 update-all and 2'b11 batch. Each code yields the busy length stated for it above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when busy is low |
| req_op_i | input | 2 | Operation code |
| req_ch_i | input | 2 | Target channel for write and read |
| req_single_i | input | 1 | Single-buffer write: load the output together with the input register |
| req_data_i | input | 48 | Data lanes, lane k = bits [k*12 +: 12] |
| busy_o | output | 1 | Sequence in progress |
| rd_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rd_data_o | output | 12 | Captured read data |
| dac_addr_o | output | 2 | DAC channel address |
| dac_rw_o | output | 1 | DAC read/write select, 1 = read |
| dac_cs_no | output | 1 | DAC chip select, active low |
| dac_ldac_no | output | 1 | DAC load strobe, active low |
| dac_data_o | output | 12 | Write data toward the DAC |
| dac_data_oe_o | output | 1 | Enable for the host bus driver |
| dac_data_i | input | 12 | Data returned from the DAC bus |

## Verification
Some properties are checked on every cycle:
- the minimum chip-select high time before each fall and the minimum low time for writes and reads,
- stable address and read/write select across the low pulse and at the rising edge,
- the output enable never coinciding with a read select,
- read-valid only in the cycle right after chip select rises on a read,
- the load strobe never low during a read access,
- the whole bus inactive whenever busy is low.

Only the bench scenarios can show the rest. These are the per-operation busy lengths and pulse counts, and which DAC registers each operation actually changes: the single-buffer path versus the common load, and the four-channel batch order. They also include sampling at the correct point of a read whose data settles late, and requests refused while busy.

// File: rtl/dac_bus_seq_pkg.sv
`timescale 1ns/1ps
package dac_bus_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_READ   = 2'b01,
    OP_UPDATE = 2'b10,
    OP_BATCH  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_LOAD
  } st_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
`timescale 1ns/1ps
module dac_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/dac_seq_rdcap.sv
`timescale 1ns/1ps
module dac_seq_rdcap #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= samp_i;
      if (samp_i) rd_data_o <= data_i;
    end
  end

endmodule

// File: rtl/dac_seq_ctrl.sv
`timescale 1ns/1ps
module dac_seq_ctrl
  import dac_bus_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 3,
  parameter int SETUP_CYC  = 2,
  parameter int WPULSE_CYC = 1,
  parameter int RPULSE_CYC = 7,
  parameter int WHOLD_CYC  = 1,
  parameter int RHOLD_CYC  = 5,
  parameter int LOAD_CYC   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [1:0]                 req_op_i,
  input  logic [$clog2(NUM_CH)-1:0]  req_ch_i,
  input  logic                       req_single_i,
  input  logic [NUM_CH*DATA_W-1:0]   req_data_i,
  input  logic                       last_i,
  output logic                       start_o,
  output logic [CNT_W-1:0]           len_o,
  output logic                       busy_o,
  output logic                       samp_o,
  output logic [$clog2(NUM_CH)-1:0]  dac_addr_o,
  output logic                       dac_rw_o,
  output logic                       dac_cs_no,
  output logic                       dac_ldac_no,
  output logic [DATA_W-1:0]          dac_data_o,
  output logic                       dac_data_oe_o
);

  localparam int CH_W = $clog2(NUM_CH);

  st_e                              state_q, state_d;
  op_e                              op_q, op_d;
  logic [CH_W-1:0]                  ch_q, ch_d;
  logic                             single_q, single_d;
  logic [NUM_CH-1:0][DATA_W-1:0]    data_q, data_d;
  logic                             adv;
  logic                             access_d;
  logic [DATA_W-1:0]                wdata_d;

  logic [CH_W-1:0]   addr_q;
  logic              rw_q, cs_n_q, ldac_n_q, oe_q;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    ch_d     = ch_q;
    single_d = single_q;
    data_d   = data_q;
    adv      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          adv      = 1'b1;
          op_d     = op_e'(req_op_i);
          single_d = req_single_i;
          data_d   = req_data_i;
          ch_d     = (op_d == OP_BATCH) ? '0 : req_ch_i;
          state_d  = (op_d == OP_UPDATE) ? ST_LOAD : ST_SETUP;
        end
      end
      ST_SETUP: if (last_i) begin adv = 1'b1; state_d = ST_PULSE; end
      ST_PULSE: if (last_i) begin adv = 1'b1; state_d = ST_HOLD;  end
      ST_HOLD: begin
        if (last_i) begin
          adv = 1'b1;
          if (op_q == OP_BATCH) begin
            if (ch_q == CH_W'(NUM_CH - 1)) state_d = ST_LOAD;
            else begin
              ch_d    = ch_q + 1'b1;
              state_d = ST_SETUP;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_LOAD: if (last_i) begin adv = 1'b1; state_d = ST_IDLE; end
      default: state_d = ST_IDLE;
    endcase
  end

  // phase length for the phase being entered
  always_comb begin
    case (state_d)
      ST_SETUP: len_o = CNT_W'(SETUP_CYC);
      ST_PULSE: len_o = (op_d == OP_READ) ? CNT_W'(RPULSE_CYC) : CNT_W'(WPULSE_CYC);
      ST_HOLD:  len_o = (op_d == OP_READ) ? CNT_W'(RHOLD_CYC)  : CNT_W'(WHOLD_CYC);
      ST_LOAD:  len_o = CNT_W'(LOAD_CYC);
      default:  len_o = CNT_W'(1);
    endcase
  end

  assign start_o  = adv && (state_d != ST_IDLE);
  assign access_d = (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);
  assign wdata_d  = (op_d == OP_BATCH) ? data_d[ch_d] : data_d[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_WRITE;
      ch_q     <= '0;
      single_q <= 1'b0;
      data_q   <= '0;
      addr_q   <= '0;
      rw_q     <= 1'b1;
      cs_n_q   <= 1'b1;
      ldac_n_q <= 1'b1;
      oe_q     <= 1'b0;
      dout_q   <= '0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      ch_q     <= ch_d;
      single_q <= single_d;
      data_q   <= data_d;
      // bus pins registered from next state: glitch free, aligned with busy
      cs_n_q   <= (state_d != ST_PULSE);
      ldac_n_q <= !((state_d == ST_LOAD) ||
                    ((state_d == ST_PULSE) && (op_d == OP_WRITE) && single_d));
      oe_q     <= access_d && (op_d != OP_READ);
      if (adv && (state_d == ST_SETUP)) begin
        addr_q <= ch_d;
        rw_q   <= (op_d == OP_READ);
        dout_q <= wdata_d;
      end
    end
  end

  // sample in the final low cycle of a read (R4)
  assign samp_o        = (state_q == ST_PULSE) && (op_q == OP_READ) && last_i;
  assign busy_o        = (state_q != ST_IDLE);
  assign dac_addr_o    = addr_q;
  assign dac_rw_o      = rw_q;
  assign dac_cs_no     = cs_n_q;
  assign dac_ldac_no   = ldac_n_q;
  assign dac_data_o    = dout_q;
  assign dac_data_oe_o = oe_q;

endmodule

// File: rtl/dac_bus_seq.sv
`timescale 1ns/1ps
module dac_bus_seq
  import dac_bus_seq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_CH   = 4,
  parameter int CLK_NS   = 20,
  parameter int T_AS_NS  = 35,
  parameter int T_CSP_NS = 35,
  parameter int T_WCS_NS = 20,
  parameter int T_WDS_NS = 35,
  parameter int T_WH_NS  = 0,
  parameter int T_RCS_NS = 130,
  parameter int T_CSD_NS = 100,
  parameter int T_DZ_NS  = 100,
  parameter int T_LD_NS  = 35
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [1:0]                 req_op_i,
  input  logic [$clog2(NUM_CH)-1:0]  req_ch_i,
  input  logic                       req_single_i,
  input  logic [NUM_CH*DATA_W-1:0]   req_data_i,
  output logic                       busy_o,
  output logic                       rd_valid_o,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [$clog2(NUM_CH)-1:0]  dac_addr_o,
  output logic                       dac_rw_o,
  output logic                       dac_cs_no,
  output logic                       dac_ldac_no,
  output logic [DATA_W-1:0]          dac_data_o,
  output logic                       dac_data_oe_o,
  input  logic [DATA_W-1:0]          dac_data_i
);

  // cs-high setup also covers the inter-access gap
  localparam int SETUP_CYC  = imax(imax(ceil_div(T_AS_NS, CLK_NS), ceil_div(T_CSP_NS, CLK_NS)), 1);
  // data is driven from setup start, so only the remainder of data setup adds to the pulse
  localparam int WPULSE_CYC = imax(imax(ceil_div(T_WCS_NS, CLK_NS),
                                        ceil_div(T_WDS_NS, CLK_NS) - SETUP_CYC), 1);
  // one spare low cycle after data valid so the last-cycle sample is settled
  localparam int RPULSE_CYC = imax(imax(ceil_div(T_RCS_NS, CLK_NS), ceil_div(T_CSD_NS, CLK_NS) + 1), 1);
  localparam int WHOLD_CYC  = imax(ceil_div(T_WH_NS, CLK_NS), 1);
  localparam int RHOLD_CYC  = imax(ceil_div(T_DZ_NS, CLK_NS), 1);
  localparam int LOAD_CYC   = imax(ceil_div(T_LD_NS, CLK_NS), 1);
  localparam int MAX_CYC    = imax(imax(imax(SETUP_CYC, RPULSE_CYC), imax(WPULSE_CYC, WHOLD_CYC)),
                                   imax(RHOLD_CYC, LOAD_CYC));
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic             tmr_start;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_last;
  logic             samp;

  dac_seq_ctrl #(
    .DATA_W     (DATA_W),
    .NUM_CH     (NUM_CH),
    .CNT_W      (CNT_W),
    .SETUP_CYC  (SETUP_CYC),
    .WPULSE_CYC (WPULSE_CYC),
    .RPULSE_CYC (RPULSE_CYC),
    .WHOLD_CYC  (WHOLD_CYC),
    .RHOLD_CYC  (RHOLD_CYC),
    .LOAD_CYC   (LOAD_CYC)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_op_i      (req_op_i),
    .req_ch_i      (req_ch_i),
    .req_single_i  (req_single_i),
    .req_data_i    (req_data_i),
    .last_i        (tmr_last),
    .start_o       (tmr_start),
    .len_o         (tmr_len),
    .busy_o        (busy_o),
    .samp_o        (samp),
    .dac_addr_o    (dac_addr_o),
    .dac_rw_o      (dac_rw_o),
    .dac_cs_no     (dac_cs_no),
    .dac_ldac_no   (dac_ldac_no),
    .dac_data_o    (dac_data_o),
    .dac_data_oe_o (dac_data_oe_o)
  );

  dac_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .len_i   (tmr_len),
    .last_o  (tmr_last)
  );

  dac_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .samp_i     (samp),
    .data_i     (dac_data_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: rtl/dac_bus_seq_chk.sv
`timescale 1ns/1ps
module dac_bus_seq_chk #(
  parameter int AW         = 2,
  parameter int SETUP_CYC  = 2,
  parameter int WPULSE_CYC = 1,
  parameter int RPULSE_CYC = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          cs_n_i,
  input logic          ldac_n_i,
  input logic          rw_i,
  input logic          oe_i,
  input logic [AW-1:0] addr_i,
  input logic          rd_valid_i
);

  logic [7:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= !cs_n_i ? 8'd0 : (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
      lo_cnt <=  cs_n_i ? 8'd0 : (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1;
    end
  end

  // R3
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |-> (hi_cnt >= 8'(SETUP_CYC)));

  // R2
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_i) |-> (lo_cnt >= 8'(WPULSE_CYC)));

  // R4
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_n_i) && $past(rw_i)) |-> (lo_cnt >= 8'(RPULSE_CYC)));

  // R2
  addr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && $past(!cs_n_i)) |-> ($stable(addr_i) && $stable(rw_i)));

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_i) |-> ($stable(addr_i) && $stable(rw_i)));

  // R6
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> !rw_i);

  // R4
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> ($rose(cs_n_i) && rw_i));

  // R7
  ldac_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_n_i |-> !(rw_i && !cs_n_i));

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cs_n_i && ldac_n_i && !oe_i && !rd_valid_i));

endmodule

bind dac_bus_seq dac_bus_seq_chk #(
  .AW         ($clog2(NUM_CH)),
  .SETUP_CYC  (SETUP_CYC),
  .WPULSE_CYC (WPULSE_CYC),
  .RPULSE_CYC (RPULSE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .cs_n_i     (dac_cs_no),
  .ldac_n_i   (dac_ldac_no),
  .rw_i       (dac_rw_o),
  .oe_i       (dac_data_oe_o),
  .addr_i     (dac_addr_o),
  .rd_valid_i (rd_valid_o)
);

// File: tb/dac_bus_seq_test.sv
`timescale 1ns/1ps
module dac_bus_seq_test;

  localparam int DW  = 12;
  localparam int NCH = 4;
  localparam int E_SETUP = 2, E_WP = 1, E_RP = 7, E_WH = 1, E_RH = 5, E_LD = 2;
  localparam logic [1:0] OPC_WR = 2'b00, OPC_RD = 2'b01, OPC_UPD = 2'b10, OPC_BAT = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid;
  logic [1:0]        req_op;
  logic [1:0]        req_ch;
  logic              req_single;
  logic [NCH*DW-1:0] req_data;
  logic              busy_o, rd_valid_o;
  logic [DW-1:0]     rd_data_o;
  logic [1:0]        dac_addr_o;
  logic              dac_rw_o, dac_cs_no, dac_ldac_no, dac_data_oe_o;
  logic [DW-1:0]     dac_data_o, dac_data_i;

  dac_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_ch_i(req_ch), .req_single_i(req_single), .req_data_i(req_data),
    .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .dac_addr_o(dac_addr_o), .dac_rw_o(dac_rw_o), .dac_cs_no(dac_cs_no),
    .dac_ldac_no(dac_ldac_no), .dac_data_o(dac_data_o), .dac_data_oe_o(dac_data_oe_o),
    .dac_data_i(dac_data_i)
  );

  // DAC pin model: level-sensitive input/output registers, late read data
  logic [DW-1:0] m_in [NCH];
  logic [DW-1:0] m_out[NCH];
  int            m_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin m_in[k] <= '0; m_out[k] <= '0; end
      m_lo <= 0;
    end else begin
      m_lo <= dac_cs_no ? 0 : m_lo + 1;
      if (!dac_cs_no && !dac_rw_o) begin
        m_in[dac_addr_o] <= dac_data_oe_o ? dac_data_o : ~dac_data_o;
        if (!dac_ldac_no) m_out[dac_addr_o] <= dac_data_oe_o ? dac_data_o : ~dac_data_o;
      end else if (dac_cs_no && !dac_ldac_no) begin
        for (int k = 0; k < NCH; k++) m_out[k] <= m_in[k];
      end
    end
  end

  assign dac_data_i = (!dac_cs_no && dac_rw_o && m_lo >= 5) ? m_in[dac_addr_o] : ~m_in[dac_addr_o];

  logic [DW-1:0] e_in [NCH];
  logic [DW-1:0] e_out[NCH];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_busy(input logic [1:0] op);
    case (op)
      OPC_WR:  return E_SETUP + E_WP + E_WH;
      OPC_RD:  return E_SETUP + E_RP + E_RH;
      OPC_UPD: return E_LD;
      default: return NCH * (E_SETUP + E_WP + E_WH) + E_LD;
    endcase
  endfunction

  function automatic int exp_cs(input logic [1:0] op);
    case (op)
      OPC_WR:  return E_WP;
      OPC_RD:  return E_RP;
      OPC_UPD: return 0;
      default: return NCH * E_WP;
    endcase
  endfunction

  function automatic int exp_ldac(input logic [1:0] op, input bit single);
    case (op)
      OPC_WR:  return single ? E_WP : 0;
      OPC_RD:  return 0;
      default: return E_LD;
    endcase
  endfunction

  function automatic int exp_oe(input logic [1:0] op);
    case (op)
      OPC_WR:  return E_SETUP + E_WP + E_WH;
      OPC_BAT: return NCH * (E_SETUP + E_WP + E_WH);
      default: return 0;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [1:0] ch,
                        input logic [NCH*DW-1:0] data, input bit single, input bit inject);
    int c_busy, c_cs, c_ld, c_oe, c_both, c_rv, c_pre, c_post, guard;
    bit seen_low;
    logic [DW-1:0] rdv, exp_rd;
    string rq, tg;
    c_busy = 0; c_cs = 0; c_ld = 0; c_oe = 0; c_both = 0; c_rv = 0;
    c_pre = 0; c_post = 0; guard = 0; seen_low = 1'b0; rdv = '0;
    exp_rd = e_in[ch];
    case (op)
      OPC_WR:  rq = "R2";
      OPC_RD:  rq = "R4";
      OPC_UPD: rq = "R8";
      default: rq = "R9";
    endcase
    @(negedge clk);
    check(!busy_o, "R1", "idle before request", int'(busy_o), 0);
    req_valid = 1'b1; req_op = op; req_ch = ch; req_data = data; req_single = single;
    @(negedge clk);
    if (inject) begin
      // R10: competing single-buffer write to another channel while busy
      req_op = OPC_WR; req_ch = ~ch; req_data = ~data; req_single = 1'b1;
    end else req_valid = 1'b0;
    while (busy_o && guard < 100) begin
      c_busy++;
      if (!dac_cs_no) begin c_cs++; seen_low = 1'b1; end
      else if (!seen_low) c_pre++;
      else c_post++;
      if (!dac_ldac_no) c_ld++;
      if (dac_data_oe_o) c_oe++;
      if (!dac_ldac_no && !dac_cs_no) c_both++;
      if (rd_valid_o) begin c_rv++; rdv = rd_data_o; end
      guard++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    check(c_busy == exp_busy(op), "R11", "busy cycles for op code", c_busy, exp_busy(op));
    check(c_cs == exp_cs(op), rq, "chip select low cycles", c_cs, exp_cs(op));
    tg = (op == OPC_WR || op == OPC_RD) ? "R7" : rq;
    check(c_ld == exp_ldac(op, single), tg, "load strobe low cycles", c_ld, exp_ldac(op, single));
    check(c_oe == exp_oe(op), "R6", "output enable cycles", c_oe, exp_oe(op));
    check(c_both == ((op == OPC_WR && single) ? E_WP : 0), "R7", "load low during cs low",
          c_both, (op == OPC_WR && single) ? E_WP : 0);
    check(c_rv == ((op == OPC_RD) ? 1 : 0), "R4", "read valid pulses", c_rv, (op == OPC_RD) ? 1 : 0);
    if (op == OPC_WR || op == OPC_RD)
      check(c_pre == E_SETUP, "R3", "cs high setup cycles", c_pre, E_SETUP);
    if (op == OPC_WR) check(c_post == E_WH, "R2", "hold cycles after write", c_post, E_WH);
    if (op == OPC_RD) begin
      check(c_post == E_RH, "R5", "bus release cycles after read", c_post, E_RH);
      check(rdv == exp_rd, "R4", "read data", int'(rdv), int'(exp_rd));
    end
    case (op)
      OPC_WR: begin
        e_in[ch] = data[DW-1:0];
        if (single) e_out[ch] = data[DW-1:0];
      end
      OPC_UPD: for (int k = 0; k < NCH; k++) e_out[k] = e_in[k];
      OPC_BAT: for (int k = 0; k < NCH; k++) begin
        e_in[k]  = data[k*DW +: DW];
        e_out[k] = data[k*DW +: DW];
      end
      default: ;
    endcase
    tg = inject ? "R10" : rq;
    for (int k = 0; k < NCH; k++) begin
      check(m_in[k] == e_in[k], tg, "DAC input register", int'(m_in[k]), int'(e_in[k]));
      check(m_out[k] == e_out[k], tg, "DAC output register", int'(m_out[k]), int'(e_out[k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < NCH; k++) begin e_in[k] = '0; e_out[k] = '0; end
    req_valid = 1'b0; req_op = '0; req_ch = '0; req_single = 1'b0; req_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dac_cs_no && dac_ldac_no, "R1", "strobes inactive after reset", {dac_cs_no, dac_ldac_no}, 3);
    check(!dac_data_oe_o && !busy_o && !rd_valid_o, "R1", "oe/busy/valid low after reset",
          {dac_data_oe_o, busy_o, rd_valid_o}, 0);

    run_op(OPC_WR,  2'd3, {36'h0, 12'hFFF}, 1'b1, 1'b0);   // single-buffer, full scale
    run_op(OPC_WR,  2'd0, {36'h0, 12'h123}, 1'b0, 1'b0);   // double-buffer
    run_op(OPC_RD,  2'd0, '0, 1'b0, 1'b0);
    run_op(OPC_UPD, 2'd2, '0, 1'b0, 1'b0);
    run_op(OPC_BAT, 2'd1, {12'h800, 12'h001, 12'h5A5, 12'hA5A}, 1'b0, 1'b0);
    run_op(OPC_RD,  2'd3, '0, 1'b0, 1'b0);
    run_op(OPC_WR,  2'd1, {36'h0, 12'h7FF}, 1'b0, 1'b0);   // write right after read
    run_op(OPC_WR,  2'd2, {36'h0, 12'h456}, 1'b0, 1'b1);   // request while busy
    run_op(OPC_BAT, 2'd0, {12'h111, 12'h222, 12'h333, 12'h444}, 1'b1, 1'b1);
    run_op(OPC_UPD, 2'd0, '0, 1'b0, 1'b1);

    for (int i = 0; i < 200; i++) begin
      logic [1:0] op, ch;
      logic [NCH*DW-1:0] d;
      bit sg, inj;
      op  = 2'($urandom_range(0, 3));
      ch  = 2'($urandom_range(0, 3));
      d   = {$urandom(), $urandom()};
      sg  = bit'($urandom_range(0, 1));
      inj = ($urandom_range(0, 7) == 0);
      run_op(op, ch, d, sg, inj);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule